// File: doc/BRIEF.md
# Every-Nth Packet Dropper

This block is one stage of a packet pipeline whose bus carries a 64-bit data word and an 8-bit control word per beat, moved by a write strobe from upstream and a ready flag from downstream. Each packet opens with one or more module-header words, which carry a nonzero control value. Payload words follow with a control value of zero, and the packet ends on the next word whose control value is nonzero again. The stage passes traffic straight through, unchanged and without delay. When dropping is switched on, it removes one whole packet out of every N and forwards all the others.

Software sets two registers through a small write port: the packet interval N and an enable bit. A 16-bit packet counter steps once at the first word of every packet. It returns to zero when a packet is chosen for removal, and an external one-cycle clear pulse also zeroes it. The pass/drop choice is made from the counter, N and the enable bit on the packet's first word, and it is held until the packet's last word. A packet is therefore either forwarded whole or discarded whole, and register writes take effect only at the next packet start. The words of a discarded packet are still accepted from upstream so that the packet drains, even while downstream is stalled.

Top module: `every_nth_dropper`

## Requirements
- R1: After reset the counter reads 0, dropping is disabled, N holds 10, and out_wr stays low while in_wr is low.
- R2: While dropping is disabled, every word is forwarded with out_data equal to in_data and out_ctrl equal to in_ctrl, and out_wr is high exactly when in_wr and out_rdy are both high.
- R3: The first word accepted after reset, or after an end-of-packet word, starts a packet. Nonzero-control words before the first zero-control word are headers. The first nonzero-control word after a zero-control word ends the packet. pkt_count rises by 1 on every packet start that is not dropped.
- R4: With dropping enabled and N of 2 or more, a packet is dropped when pkt_count+1 at its start is at least N, and pkt_count then returns to 0. Counting from a zero counter, this drops packets N, 2N, 3N and so on.
- R5: With dropping enabled and N equal to 0 or 1, every packet is dropped and pkt_count stays at 0.
- R6: No word of a dropped packet raises out_wr, and in_rdy stays high for all of its words even while out_rdy is low.
- R7: The pass/drop choice is fixed on the packet's first word. A register write in that cycle or later within the packet does not change it, and the new value applies from the next packet start.
- R8: A high count_clear makes pkt_count 0 on the next cycle. This takes priority over an increment in the same cycle.
- R9: For a forwarded packet, in_rdy equals out_rdy, and out_wr is never high while out_rdy is low.
- R10: A write with cfg_sel 0 loads N from cfg_wdata. A write with cfg_sel 1 loads the enable bit from cfg_wdata bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 64 | Upstream data word |
| in_ctrl | input | 8 | Upstream control word (nonzero = header or end of packet) |
| in_wr | input | 1 | Upstream word valid |
| in_rdy | output | 1 | Stage can accept a word |
| out_data | output | 64 | Downstream data word |
| out_ctrl | output | 8 | Downstream control word |
| out_wr | output | 1 | Downstream word valid |
| out_rdy | input | 1 | Downstream can accept a word |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 = interval N, 1 = enable |
| cfg_wdata | input | 16 | Register write data |
| count_clear | input | 1 | One-cycle pulse that zeroes the packet counter |
| pkt_count | output | 16 | Current packet counter value |

## Verification
The counter can receive an increment and a clear in the same cycle. This happens in two ways: a drop decision on a packet's first word issues its own clear, and an external count_clear pulse can coincide with a packet start. The bench provokes both. It drives count_clear on the first word of a packet and checks that the counter reads 0 afterwards while that packet's pass/drop outcome still follows the old count. It also checks a register write that lands on a packet's first word: that packet must follow the old settings, and the following packet must follow the new ones.

// File: rtl/nth_drop_pkg.sv
package nth_drop_pkg;

    // Position of the framing tracker within a packet
    typedef enum logic [1:0] {
        FR_GAP  = 2'd0,   // between packets: next accepted word is a start
        FR_HDR  = 2'd1,   // inside module headers
        FR_BODY = 2'd2    // inside payload, waiting for end-of-packet word
    } frame_st_t;

    // Register select codes
    localparam logic CFG_SEL_INTERVAL = 1'b0;
    localparam logic CFG_SEL_ENABLE   = 1'b1;

endpackage

// File: rtl/nth_frame_tracker.sv
// nth_frame_tracker
//   Follows packet framing on the control lane. A packet starts on the
//   first accepted word after a gap, stays in headers while control is
//   nonzero, enters payload on the first zero control word, and ends on
//   the next nonzero control word.
//   Assumes: every packet has at least one zero-control payload word.
module nth_frame_tracker
    import nth_drop_pkg::*;
#(
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,       // word transferred this cycle
    input  logic [CTRL_W-1:0] ctrl,
    output logic              sof,       // accepted word is a packet start
    output logic              in_pkt     // a packet is open
);

    frame_st_t st_q;
    frame_st_t st_d;
    logic      ctrl_nz;

    assign ctrl_nz = |ctrl;
    assign sof     = acc && (st_q == FR_GAP);
    assign in_pkt  = (st_q != FR_GAP);

    // Next framing state from the accepted word
    always_comb begin
        st_d = st_q;
        if (acc) begin
            case (st_q)
                FR_GAP:  st_d = ctrl_nz ? FR_HDR : FR_BODY;
                FR_HDR:  st_d = ctrl_nz ? FR_HDR : FR_BODY;
                FR_BODY: st_d = ctrl_nz ? FR_GAP : FR_BODY;
                default: st_d = FR_GAP;
            endcase
        end
    end

    // Framing state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FR_GAP;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/nth_cfg_regs.sv
// nth_cfg_regs
//   Holds the two software registers: the drop interval N and the
//   enable bit. Writes land on the clock edge of the strobe.
//   Assumes: cfg_sel selects one register per write.
module nth_cfg_regs
    import nth_drop_pkg::*;
#(
    parameter int          CNT_W = 16,
    parameter logic [15:0] DEF_N = 16'd10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             sel,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] interval,
    output logic             enable
);

    // Interval register
    always_ff @(posedge clk) begin
        if (!rst_n)                            interval <= CNT_W'(DEF_N);
        else if (we && sel == CFG_SEL_INTERVAL) interval <= wdata;
    end

    // Enable register
    always_ff @(posedge clk) begin
        if (!rst_n)                          enable <= 1'b0;
        else if (we && sel == CFG_SEL_ENABLE) enable <= wdata[0];
    end

endmodule

// File: rtl/nth_pulse_counter.sv
// nth_pulse_counter
//   Packet counter driven by two one-cycle pulses: inc adds one, clr
//   zeroes it. A clear in the same cycle as an increment wins.
//   Assumes: the count wraps at its width.
module nth_pulse_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);

    // Count update with clear priority
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (inc) count <= count + 1'b1;
    end

endmodule

// File: rtl/nth_drop_decider.sv
// nth_drop_decider
//   Forms the pass/drop choice for a packet on its first word and holds
//   it for the rest of the packet.
//   Assumes: sof only occurs while no packet is open.
module nth_drop_decider #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             in_pkt,
    input  logic             enable,
    input  logic [CNT_W-1:0] interval,
    input  logic [CNT_W-1:0] count,
    output logic             start_drop, // choice a start would get now
    output logic             drop_q,     // choice held for the open packet
    output logic             drop_now    // choice for the present word
);

    logic [CNT_W:0] next_cnt;
    logic           small_n;

    assign next_cnt = {1'b0, count} + 1'b1;
    assign small_n  = (interval <= CNT_W'(1));

    // Choice for a packet starting in this cycle
    always_comb begin
        start_drop = enable && (small_n || (next_cnt >= {1'b0, interval}));
    end

    assign drop_now = in_pkt ? drop_q : start_drop;

    // Latch the choice at packet start
    always_ff @(posedge clk) begin
        if (!rst_n)   drop_q <= 1'b0;
        else if (sof) drop_q <= start_drop;
    end

endmodule

// File: rtl/every_nth_dropper.sv
// every_nth_dropper
//   Pipeline stage that forwards packets unchanged and, when enabled,
//   discards one whole packet out of every N. Words of a discarded
//   packet are accepted and never written downstream.
//   Assumes: upstream holds a word stable until it is accepted.
module every_nth_dropper #(
    parameter int          DATA_W = 64,
    parameter int          CTRL_W = 8,
    parameter int          CNT_W  = 16,
    parameter logic [15:0] DEF_N  = 16'd10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CTRL_W-1:0] in_ctrl,
    input  logic              in_wr,
    output logic              in_rdy,
    output logic [DATA_W-1:0] out_data,
    output logic [CTRL_W-1:0] out_ctrl,
    output logic              out_wr,
    input  logic              out_rdy,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [CNT_W-1:0]  cfg_wdata,
    input  logic              count_clear,
    output logic [CNT_W-1:0]  pkt_count
);

    logic             acc;
    logic             sof;
    logic             in_pkt;
    logic             start_drop;
    logic             drop_q;
    logic             drop_now;
    logic             cnt_clr;
    logic             en_q;
    logic [CNT_W-1:0] n_q;

    // Handshake: dropped words drain regardless of downstream
    assign in_rdy   = drop_now | out_rdy;
    assign acc      = in_wr & in_rdy;
    assign out_wr   = acc & ~drop_now;
    assign out_data = in_data;
    assign out_ctrl = in_ctrl;
    assign cnt_clr  = count_clear | (sof & start_drop);

    nth_frame_tracker #(.CTRL_W(CTRL_W)) i_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc    (acc),
        .ctrl   (in_ctrl),
        .sof    (sof),
        .in_pkt (in_pkt)
    );

    nth_cfg_regs #(.CNT_W(CNT_W), .DEF_N(DEF_N)) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .sel      (cfg_sel),
        .wdata    (cfg_wdata),
        .interval (n_q),
        .enable   (en_q)
    );

    nth_pulse_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (sof),
        .clr   (cnt_clr),
        .count (pkt_count)
    );

    nth_drop_decider #(.CNT_W(CNT_W)) i_decide (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof        (sof),
        .in_pkt     (in_pkt),
        .enable     (en_q),
        .interval   (n_q),
        .count      (pkt_count),
        .start_drop (start_drop),
        .drop_q     (drop_q),
        .drop_now   (drop_now)
    );

endmodule

// File: rtl/every_nth_dropper_chk.sv
// every_nth_dropper_chk
//   Property checker bound to every_nth_dropper.
module every_nth_dropper_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_rdy,
    input logic             out_wr,
    input logic             out_rdy,
    input logic             count_clear,
    input logic [CNT_W-1:0] pkt_count,
    input logic             sof,
    input logic             in_pkt,
    input logic             start_drop,
    input logic             drop_q,
    input logic             drop_now,
    input logic             en_q,
    input logic [CNT_W-1:0] n_q
);

    // R6: dropped words never reach downstream
    a_r6_no_write_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        drop_now |-> !out_wr);

    // R6: dropped packet drains
    a_r6_drain_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        drop_now |-> in_rdy);

    // R9: no downstream write without ready
    a_r9_wr_needs_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr |-> out_rdy);

    // R8: clear pulse zeroes the counter
    a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        count_clear |=> (pkt_count == '0));

    // R3: a passed start steps the counter by one
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (sof && !count_clear && !start_drop) |=> (pkt_count == $past(pkt_count) + 1'b1));

    // R3: counter holds between starts
    a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof && !count_clear) |=> $stable(pkt_count));

    // R4: a drop restarts the count
    a_r4_drop_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (sof && start_drop) |=> (pkt_count == '0));

    // R5: small interval drops every packet
    a_r5_small_n_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (sof && en_q && (n_q <= CNT_W'(1))) |-> drop_now);

    // R7: choice held across an open packet
    a_r7_choice_held: assert property (@(posedge clk) disable iff (!rst_n)
        in_pkt |=> $stable(drop_q));

endmodule

bind every_nth_dropper every_nth_dropper_chk #(.CNT_W(CNT_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_rdy      (in_rdy),
    .out_wr      (out_wr),
    .out_rdy     (out_rdy),
    .count_clear (count_clear),
    .pkt_count   (pkt_count),
    .sof         (sof),
    .in_pkt      (in_pkt),
    .start_drop  (start_drop),
    .drop_q      (drop_q),
    .drop_now    (drop_now),
    .en_q        (en_q),
    .n_q         (n_q)
);

// File: tb/test_every_nth_dropper.sv
module test_every_nth_dropper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] in_data = '0;
    logic [7:0]  in_ctrl = '0;
    logic        in_wr = 1'b0;
    logic        in_rdy;
    logic [63:0] out_data;
    logic [7:0]  out_ctrl;
    logic        out_wr;
    logic        out_rdy = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        count_clear = 1'b0;
    logic [15:0] pkt_count;

    int tests = 0;
    int fails = 0;

    // Bench model built from the requirements
    int m_cnt = 0;
    int m_n   = 10;
    bit m_en  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    every_nth_dropper i_every_nth_dropper (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_ctrl(in_ctrl),
        .in_wr(in_wr), .in_rdy(in_rdy), .out_data(out_data), .out_ctrl(out_ctrl),
        .out_wr(out_wr), .out_rdy(out_rdy), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .count_clear(count_clear), .pkt_count(pkt_count)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit model_drop();
        return m_en && (m_n <= 1 || (m_cnt + 1) >= m_n);
    endfunction

    task automatic cfg_write(input bit sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = 16'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel) m_en = val[0]; else m_n = val & 16'hFFFF;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        count_clear = 1'b1;
        @(negedge clk);
        count_clear = 1'b0;
        m_cnt = 0;
    endtask

    // One packet: two headers, nbody payload words, one end word.
    // cfg_at >= 0 issues a register write on that word; clr_start pulses
    // count_clear on the first word; stall holds out_rdy low at first.
    task automatic send_pkt(input int nbody, input bit stall, input int cfg_at,
                            input bit csel, input int cval, input bit clr_start,
                            input string req);
        bit d;
        int nw;
        d  = model_drop();
        nw = nbody + 3;
        for (int w = 0; w < nw; w++) begin
            @(negedge clk);
            cfg_we = 1'b0; count_clear = 1'b0;
            in_wr   = 1'b1;
            in_data = {32'hC0DE_0000 + 32'(m_cnt), 32'(w)};
            in_ctrl = (w == 0) ? 8'hFF : (w == 1) ? 8'hFE : (w == nw - 1) ? 8'h10 : 8'h00;
            if (w == cfg_at) begin cfg_we = 1'b1; cfg_sel = csel; cfg_wdata = 16'(cval); end
            if (w == 0 && clr_start) count_clear = 1'b1;
            out_rdy = stall ? 1'b0 : 1'b1;
            #2;
            if (stall) begin
                check(in_rdy == d, {req, " in_rdy under stall"}, in_rdy, d);
                check(out_wr == 1'b0, {req, " out_wr under stall"}, out_wr, 0);
                if (!d) begin
                    @(negedge clk);
                    out_rdy = 1'b1;
                    #2;
                end
            end
            if (!stall || !d) begin
                check(out_wr == !d, {req, " out_wr"}, out_wr, !d);
                check(in_rdy == 1'b1, {req, " in_rdy"}, in_rdy, 1);
            end
            if (!d) begin
                check(out_data == in_data, {req, " out_data"}, out_data, in_data);
                check(out_ctrl == in_ctrl, {req, " out_ctrl"}, out_ctrl, in_ctrl);
            end
        end
        @(negedge clk);
        in_wr = 1'b0; cfg_we = 1'b0; count_clear = 1'b0; out_rdy = 1'b1;
        // model update: decision used old values
        if (clr_start || d) m_cnt = 0; else m_cnt = (m_cnt + 1) & 16'hFFFF;
        if (cfg_at >= 0) begin
            if (csel) m_en = cval[0]; else m_n = cval & 16'hFFFF;
        end
        #2;
        check(pkt_count == 16'(m_cnt), {req, " pkt_count"}, pkt_count, m_cnt);
    endtask

    task automatic t_reset();
        #2;
        check(pkt_count == 0, "R1 count after reset", pkt_count, 0);
        check(out_wr == 0, "R1 out_wr idle", out_wr, 0);
        check(in_rdy == 1, "R1 in_rdy idle", in_rdy, 1);
        // default N=10 with enable: 10th packet drops
        cfg_write(1'b1, 1);
        for (int p = 0; p < 10; p++) send_pkt(1 + p % 3, 1'b0, -1, 1'b0, 0, 1'b0, "R1 default interval");
        check(pkt_count == 0, "R1 tenth packet restarted", pkt_count, 0);
        cfg_write(1'b1, 0);
    endtask

    task automatic t_disabled();
        for (int p = 0; p < 5; p++) send_pkt(p + 1, 1'b0, -1, 1'b0, 0, 1'b0, "R2 disabled pass");
        check(pkt_count == 5, "R3 five starts counted", pkt_count, 5);
    endtask

    task automatic t_every_n();
        pulse_clear();
        cfg_write(1'b0, 3);
        cfg_write(1'b1, 1);
        for (int p = 0; p < 9; p++) send_pkt(2, 1'b0, -1, 1'b0, 0, 1'b0, "R4 every third");
        cfg_write(1'b0, 2);
        for (int p = 0; p < 4; p++) send_pkt(1, 1'b0, -1, 1'b0, 0, 1'b0, "R10 interval two");
    endtask

    task automatic t_small_n();
        cfg_write(1'b0, 1);
        for (int p = 0; p < 3; p++) send_pkt(2, 1'b0, -1, 1'b0, 0, 1'b0, "R5 N=1");
        cfg_write(1'b0, 0);
        for (int p = 0; p < 3; p++) send_pkt(1, 1'b0, -1, 1'b0, 0, 1'b0, "R5 N=0");
        check(pkt_count == 0, "R5 count stays zero", pkt_count, 0);
    endtask

    task automatic t_backpressure();
        // dropped packet with downstream stalled
        send_pkt(2, 1'b1, -1, 1'b0, 0, 1'b0, "R6 drain under stall");
        cfg_write(1'b1, 0);
        send_pkt(2, 1'b1, -1, 1'b0, 0, 1'b0, "R9 pass under stall");
    endtask

    task automatic t_latched();
        cfg_write(1'b0, 4);
        pulse_clear();
        cfg_write(1'b1, 1);
        // enable off written mid-packet: current packet keeps its choice
        send_pkt(3, 1'b0, -1, 1'b0, 0, 1'b0, "R7 setup 1");
        send_pkt(3, 1'b0, -1, 1'b0, 0, 1'b0, "R7 setup 2");
        send_pkt(3, 1'b0, -1, 1'b0, 0, 1'b0, "R7 setup 3");
        send_pkt(3, 1'b0, 2, 1'b1, 0, 1'b0, "R7 drop held after disable");
        // N=1 written on the first word: this packet passes, next drops
        cfg_write(1'b1, 1);
        send_pkt(2, 1'b0, 0, 1'b0, 1, 1'b0, "R7 write on start word");
        send_pkt(2, 1'b0, -1, 1'b0, 0, 1'b0, "R7 new N applies");
    endtask

    task automatic t_clear_collide();
        cfg_write(1'b0, 5);
        send_pkt(1, 1'b0, -1, 1'b0, 0, 1'b0, "R8 setup a");
        send_pkt(1, 1'b0, -1, 1'b0, 0, 1'b0, "R8 setup b");
        send_pkt(1, 1'b0, -1, 1'b0, 0, 1'b1, "R8 clear beats increment");
        check(pkt_count == 0, "R8 count zero after collision", pkt_count, 0);
        pulse_clear();
        #2;
        check(pkt_count == 0, "R8 idle clear", pkt_count, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled();
        t_every_n();
        t_small_n();
        t_backpressure();
        t_latched();
        t_clear_collide();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule